// File: doc/BRIEF.md
# Register File with Write-Through Bypass

This block holds the general-purpose registers of a scalar integer pipeline: a 32-entry array of 32-bit words. Decode reads two source operands each cycle through combinational ports. Write-back stores one result per cycle on the rising clock edge.

A decode read can name the same register that write-back is storing in that cycle. The stored word is then one edge stale, so a comparator on each read port returns the incoming write data in its place. It compares against the write enable of the write-back stage. A third read port lets a bench or monitor inspect any register at any time, and it uses the same bypass. Register zero reads as zero in every case. Each decode port exports a flag that shows when its bypass is active.

Top module: `regfile_wt`

## Requirements
- R1: After reset, every register reads as zero on all three read ports.
- R2: When `wr_en` is high and `wr_idx` is nonzero, register `wr_idx` takes `wr_data` at the rising clock edge. No other register changes. Nothing changes while `wr_en` is low.
- R3: A write to index 0 is discarded. A read of index 0 returns zero on every port, even while index 0 is being written with nonzero data.
- R4: When `wr_en` is high, `wr_idx` is nonzero and `rd_a_idx` equals `wr_idx`, `rd_a_data` equals `wr_data` in that same cycle. Otherwise it returns the stored value.
- R5: The same rule as R4 holds for port B (`rd_b_idx`, `rd_b_data`).
- R6: `byp_a` is 1 exactly when `wr_en` is high, `wr_idx` is nonzero and `rd_a_idx` equals `wr_idx`. `byp_b` follows the same rule for `rd_b_idx`.
- R7: `dbg_data` returns the value of register `dbg_idx` at any time. It applies the same write-through rule as the decode ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable from the write-back stage |
| wr_idx | input | 5 | Destination register index |
| wr_data | input | 32 | Data to write |
| rd_a_idx | input | 5 | Port A source index |
| rd_a_data | output | 32 | Port A read data |
| byp_a | output | 1 | Port A bypass is active |
| rd_b_idx | input | 5 | Port B source index |
| rd_b_data | output | 32 | Port B read data |
| byp_b | output | 1 | Port B bypass is active |
| dbg_idx | input | 5 | Debug read index |
| dbg_data | output | 32 | Debug read data |

## Verification
The bench aims at cycles where write-back and a read name the same register. A design without the bypass would return the previous value there. It also drives writes to index 0 together with reads of index 0. A comparator without the zero guard would leak the write data onto a read that must stay zero.

It writes with `wr_en` low while the indices match. A design that compared against the wrong enable would raise a flag or forward data in those cycles. Both decode ports and the debug port are compared every cycle against a behavioural array model. Any crossed wiring between ports therefore shows up at once.

// File: rtl/regfile_wt.sv
module regfile_wt #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IW-1:0]   rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  output logic            byp_a,
  input  logic [IW-1:0]   rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  output logic            byp_b,
  input  logic [IW-1:0]   dbg_idx,
  output logic [XLEN-1:0] dbg_data
);
  logic [XLEN-1:0] regs [NREGS];
  logic            wr_live;
  logic            byp_d;

  assign wr_live = wr_en && (wr_idx != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wr_idx] <= wr_data;
    end
  end

  assign byp_a = wr_live && (rd_a_idx == wr_idx);
  assign byp_b = wr_live && (rd_b_idx == wr_idx);
  assign byp_d = wr_live && (dbg_idx  == wr_idx);

  assign rd_a_data = (rd_a_idx == '0) ? '0 : byp_a ? wr_data : regs[rd_a_idx];
  assign rd_b_data = (rd_b_idx == '0) ? '0 : byp_b ? wr_data : regs[rd_b_idx];
  assign dbg_data  = (dbg_idx  == '0) ? '0 : byp_d ? wr_data : regs[dbg_idx];
endmodule

// File: rtl/regfile_wt_chk.sv
module regfile_wt_chk #(
  parameter int XLEN = 32,
  parameter int IW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [IW-1:0]   wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic [IW-1:0]   rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic            byp_a,
  input logic [IW-1:0]   rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            byp_b,
  input logic [IW-1:0]   dbg_idx,
  input logic [XLEN-1:0] dbg_data
);
  assert_zero_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == '0 |-> rd_a_data == '0 && !byp_a);
  assert_zero_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == '0 |-> rd_b_data == '0 && !byp_b);
  assert_byp_a_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byp_a |-> rd_a_data == wr_data);
  assert_byp_b_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    byp_b |-> rd_b_data == wr_data);
  assert_byp_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !byp_a && !byp_b);
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx != '0 && rd_a_idx == wr_idx ##1 rd_a_idx == $past(wr_idx) && !wr_en
      |-> rd_a_data == $past(wr_data));
  assert_dbg_byp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx != '0 && dbg_idx == wr_idx |-> dbg_data == wr_data);
  assert_dbg_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_idx == '0 |-> dbg_data == '0);
endmodule

bind regfile_wt regfile_wt_chk #(.XLEN(XLEN), .IW(IW)) u_chk (.*);

// File: tb/sim_regfile_wt.sv
`timescale 1ns/1ps
module sim_regfile_wt;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0;
  logic [4:0]  wr_idx = 0, rd_a_idx = 0, rd_b_idx = 0, dbg_idx = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_a_data, rd_b_data, dbg_data;
  logic        byp_a, byp_b;
  int total = 0, bad = 0;
  logic [31:0] model [32];
  bit done = 0;

  always #5 clk = ~clk;

  regfile_wt u0 (.*);

  function automatic logic [31:0] ref_rd(input logic [4:0] idx);
    if (idx == 0) return 0;
    if (wr_en && wr_idx != 0 && wr_idx == idx) return wr_data;
    return model[idx];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(wr_en ? "R4" : "R2", rd_a_data, ref_rd(rd_a_idx));
    chk(wr_en ? "R5" : "R2", rd_b_data, ref_rd(rd_b_idx));
    chk("R7", dbg_data, ref_rd(dbg_idx));
    chk("R6", {31'd0, byp_a}, {31'd0, wr_en && wr_idx != 0 && rd_a_idx == wr_idx});
    chk("R6", {31'd0, byp_b}, {31'd0, wr_en && wr_idx != 0 && rd_b_idx == wr_idx});
    if (rd_a_idx == 0) chk("R3", rd_a_data, 0);
  endtask

  task automatic cyc(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                     input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
    @(negedge clk);
    wr_en = we; wr_idx = wi; wr_data = wd; rd_a_idx = a; rd_b_idx = b; dbg_idx = d;
    #1 check_all();
    @(posedge clk);
    if (we && wi != 0) model[wi] = wd;
  endtask

  initial begin
    #20000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 0;
    #22 rst_n = 1;
    for (int i = 0; i < 32; i++) cyc(0, 0, 0, 5'(i), 5'(31 - i), 5'(i)); // R1
    for (int i = 1; i < 32; i++) cyc(1, 5'(i), 32'h1000 + i * 7, 5'(i - 1), 5'(i), 5'(i)); // R4 R5 R7
    cyc(1, 0, 32'hDEAD_BEEF, 0, 0, 0); // R3
    cyc(0, 0, 0, 0, 0, 0);             // R3
    cyc(0, 9, 32'hFFFF_0000, 9, 9, 9); // R6 disabled write R2
    cyc(0, 0, 0, 9, 9, 9);             // R2 unchanged
    cyc(1, 12, 32'hCAFE_0012, 12, 3, 12);
    cyc(1, 12, 32'hCAFE_1212, 12, 12, 4);
    cyc(0, 0, 0, 12, 12, 12);
    for (int i = 0; i < 400; i++)
      cyc(1'($urandom), 5'($urandom), $urandom, 5'($urandom), 5'($urandom), 5'($urandom));
    for (int i = 0; i < 32; i++) cyc(0, 0, 0, 5'(i), 5'(i), 5'(i)); // R2 final
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule